// File: doc/BRIEF.md
# Vectored interrupt request responder

This block is the peripheral-side interrupt controller for eight request lines. A rising level on any line records that request as pending. When an unmasked pending request is not blocked by service already in progress, the block raises its interrupt output towards the processor. The processor answers with two active-low acknowledge pulses. The first pulse freezes the choice of request and moves it into service; nothing goes on the data bus. During the second pulse the block drives a single vector byte, which selects one of 256 interrupt types.

The vector byte is the upper five bits of a programmable base joined to the three-bit number of the serviced line. Types below 32 are reserved, so a base write that would produce such a vector is refused. Software writes the base and a per-line mask through a small write port. A one-cycle end-of-service pulse retires the most important request still in service. Priority is fixed, and line 0 is the most important.

The acknowledge input is sampled on the block clock, and each acknowledge pulse must last at least one clock cycle. The vector is only valid while `vec_oe` is high; at all other times the bus driver is expected to be released.

Top module: `vir_responder`

## Requirements
- R1: After reset, `int_req` and `vec_oe` are low, `vec_data` is 0, all eight lines are masked and the base is 0x20. A 0-to-1 transition on `irq_lines[i]` sets line i pending, and the pending bit stays set after the line falls.
- R2: A write with `cfg_sel`=1 loads the mask, where bit i = 1 masks line i. A masked pending line never causes `int_req`. Its pending bit is kept, so unmasking it later raises `int_req`.
- R3: Among eligible requests, the lowest line number wins. The vector is `{base[7:3], line[2:0]}`.
- R4: When `ack_n` goes low while no acknowledge is in progress, the winning line's pending bit is cleared and its in-service bit is set. `vec_oe` stays low and `vec_data` stays 0 throughout this first pulse.
- R5: `vec_oe` is high, and `vec_data` carries the vector, only while the second `ack_n` pulse is low. Otherwise `vec_oe` is low and `vec_data` is 0.
- R6: `int_req` stays high from the first acknowledge pulse until the second one ends. Afterwards it is high only if an unmasked pending request of higher priority than every in-service line exists.
- R7: An in-service line blocks requests on lines of the same or lower priority. An `eos` pulse clears the lowest-numbered in-service bit.
- R8: A write with `cfg_sel`=0 loads `cfg_wdata[7:3]` as the base, unless `{cfg_wdata[7:3],3'b000}` is below 32. In that case the write is ignored.
- R9: A first acknowledge with no eligible request gives line number 7 in the vector and puts no line in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 8 | Request lines, index 0 most important |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the base, 1 selects the mask |
| cfg_wdata | input | 8 | Configuration write data |
| eos | input | 1 | End-of-service pulse |
| ack_n | input | 1 | Interrupt acknowledge from the processor, active low |
| int_req | output | 1 | Interrupt request to the processor |
| vec_oe | output | 1 | Data bus drive enable |
| vec_data | output | 8 | Vector byte, 0 when not driven |

## Verification
On every cycle, the assertions check four things. Bus drive only happens while acknowledge is low, and a driven vector never falls below 32. A request is never granted on a masked line. The interrupt output holds through an acknowledge, and the in-service set changes as expected on acknowledge and on end of service. Only the directed scenarios can show the rest. These are the actual vector values and the priority order between simultaneous requests, the blocking and release of nested service, the retention of masked pending bits, the refused base writes, and the spurious-acknowledge response.

// File: rtl/vir_pkg.sv
package vir_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ACK1 = 2'd1,
    SQ_GAP  = 2'd2,
    SQ_ACK2 = 2'd3
  } seq_t;
endpackage

// File: rtl/vir_capture.sv
module vir_capture #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines,
  input  logic [NUM_LINES-1:0] clr,
  output logic [NUM_LINES-1:0] pend
);
  logic [NUM_LINES-1:0] lines_q;
  logic [NUM_LINES-1:0] pend_nx;
  logic [NUM_LINES-1:0] rise;

  always_comb begin
    rise    = lines & ~lines_q;
    pend_nx = (pend & ~clr) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= '0;
      pend    <= '0;
    end else begin
      lines_q <= lines;
      pend    <= pend_nx;
    end
  end

  AST_RISE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (lines != '0 && lines_q == '0) |=> (pend != '0)); // R1
endmodule

// File: rtl/vir_resolve.sv
module vir_resolve #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] pend,
  input  logic [NUM_LINES-1:0] mask,
  input  logic [NUM_LINES-1:0] isr,
  output logic                 req_valid,
  output logic [IDX_W-1:0]     req_idx
);
  logic [NUM_LINES-1:0] cand;
  logic                 stop;

  always_comb begin
    cand      = pend & ~mask;
    req_valid = 1'b0;
    req_idx   = '0;
    stop      = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (!stop) begin
        if (isr[i]) begin
          stop = 1'b1;
        end else if (cand[i]) begin
          req_valid = 1'b1;
          req_idx   = IDX_W'(i);
          stop      = 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (req_valid) begin
      AST_GRANT_UNMASKED: assert (!mask[req_idx] && pend[req_idx]); // R2
    end
  end
endmodule

// File: rtl/vir_ack_seq.sv
module vir_ack_seq
  import vir_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ack_n,
  input  logic                 eos,
  input  logic                 req_valid,
  input  logic [IDX_W-1:0]     req_idx,
  output logic [NUM_LINES-1:0] clr,
  output logic [NUM_LINES-1:0] isr,
  output logic [IDX_W-1:0]     frz_idx,
  output logic                 in_seq,
  output logic                 oe
);
  seq_t                 state, state_nx;
  logic [NUM_LINES-1:0] isr_nx;
  logic [NUM_LINES-1:0] eos_clr;
  logic [IDX_W-1:0]     frz_nx;
  logic                 first;
  logic                 take;
  logic                 hit;

  always_comb begin
    first = (state == SQ_IDLE) && !ack_n;
    take  = first && req_valid;
    clr   = take ? (NUM_LINES'(1) << req_idx) : '0;
  end

  always_comb begin
    eos_clr = '0;
    hit     = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (isr[i] && !hit) begin
        eos_clr[i] = 1'b1;
        hit        = 1'b1;
      end
    end
    eos_clr = eos ? eos_clr : '0;
    isr_nx  = (isr & ~eos_clr) | clr;
  end

  always_comb begin
    state_nx = state;
    frz_nx   = frz_idx;
    case (state)
      SQ_IDLE: if (!ack_n) begin
        state_nx = SQ_ACK1;
        frz_nx   = req_valid ? req_idx : {IDX_W{1'b1}};
      end
      SQ_ACK1: if (ack_n)  state_nx = SQ_GAP;
      SQ_GAP:  if (!ack_n) state_nx = SQ_ACK2;
      SQ_ACK2: if (ack_n)  state_nx = SQ_IDLE;
      default: state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      isr     <= '0;
      frz_idx <= '0;
    end else begin
      state   <= state_nx;
      isr     <= isr_nx;
      frz_idx <= frz_nx;
    end
  end

  always_comb begin
    in_seq = (state != SQ_IDLE);
    oe     = ((state == SQ_GAP) || (state == SQ_ACK2)) && !ack_n;
  end

  AST_ISR_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (isr != '0)); // R4
  AST_EOS_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && isr != '0 && !take) |=> ($countones(isr) < $past($countones(isr)))); // R7
endmodule

// File: rtl/vir_responder.sv
module vir_responder
  import vir_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int VEC_W       = 8,
  parameter int RSVD_TYPES  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [VEC_W-1:0]     cfg_wdata,
  input  logic                 eos,
  input  logic                 ack_n,
  output logic                 int_req,
  output logic                 vec_oe,
  output logic [VEC_W-1:0]     vec_data
);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int BASE_W = VEC_W - IDX_W;

  logic [NUM_LINES-1:0] pend, clr, isr, mask, mask_nx;
  logic [BASE_W-1:0]    base_hi, base_nx;
  logic [VEC_W-1:0]     base_cand;
  logic [IDX_W-1:0]     req_idx, frz_idx;
  logic                 req_valid, in_seq, oe;

  always_comb begin
    base_cand = {cfg_wdata[VEC_W-1:IDX_W], {IDX_W{1'b0}}};
    base_nx   = base_hi;
    mask_nx   = mask;
    if (cfg_we && !cfg_sel && (base_cand >= VEC_W'(RSVD_TYPES)))
      base_nx = cfg_wdata[VEC_W-1:IDX_W];
    if (cfg_we && cfg_sel)
      mask_nx = cfg_wdata[NUM_LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi <= BASE_W'(RSVD_TYPES >> IDX_W);
      mask    <= '1;
    end else begin
      base_hi <= base_nx;
      mask    <= mask_nx;
    end
  end

  vir_capture #(.NUM_LINES(NUM_LINES)) u_capture (
    .clk   (clk),
    .rst_n (rst_n),
    .lines (irq_lines),
    .clr   (clr),
    .pend  (pend)
  );

  vir_resolve #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_resolve (
    .pend      (pend),
    .mask      (mask),
    .isr       (isr),
    .req_valid (req_valid),
    .req_idx   (req_idx)
  );

  vir_ack_seq #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_ack_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_n     (ack_n),
    .eos       (eos),
    .req_valid (req_valid),
    .req_idx   (req_idx),
    .clr       (clr),
    .isr       (isr),
    .frz_idx   (frz_idx),
    .in_seq    (in_seq),
    .oe        (oe)
  );

  always_comb begin
    int_req  = in_seq | req_valid;
    vec_oe   = oe;
    vec_data = oe ? {base_hi, frz_idx} : '0;
  end

  AST_OE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> !ack_n); // R5
  AST_VEC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (vec_data >= VEC_W'(RSVD_TYPES))); // R8
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && !in_seq) |-> ((pend & ~mask) != '0)); // R2
  AST_INT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && int_req) |=> int_req); // R6
endmodule

// File: tb/test_vir_responder.sv
`timescale 1ns/1ps
module test_vir_responder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_lines;
  logic       cfg_we, cfg_sel, eos, ack_n;
  logic [7:0] cfg_wdata;
  logic       int_req, vec_oe;
  logic [7:0] vec_data;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vir_responder i_vir_responder (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .eos(eos), .ack_n(ack_n),
    .int_req(int_req), .vec_oe(vec_oe), .vec_data(vec_data)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  task automatic cfg_write(bit sel, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    #0.5;
  endtask

  task automatic raise(int line);
    @(negedge clk);
    irq_lines[line] = 1'b1;
    @(negedge clk);
    irq_lines[line] = 1'b0;
    #0.5;
  endtask

  task automatic end_service();
    @(negedge clk);
    eos = 1'b1;
    @(negedge clk);
    eos = 1'b0;
    #0.5;
  endtask

  // full two-pulse acknowledge; returns the driven vector
  task automatic acknowledge(string tag, output logic [7:0] vec);
    @(negedge clk);
    ack_n = 1'b0;
    #0.5;
    chk({tag, " R4 oe in first pulse"}, vec_oe, 0);
    chk({tag, " R4 data in first pulse"}, vec_data, 0);
    cyc(1);
    chk({tag, " R6 int during first pulse"}, int_req, 1);
    @(negedge clk);
    ack_n = 1'b1;
    #0.5;
    chk({tag, " R5 oe between pulses"}, vec_oe, 0);
    cyc(1);
    chk({tag, " R6 int between pulses"}, int_req, 1);
    @(negedge clk);
    ack_n = 1'b0;
    #0.5;
    chk({tag, " R5 oe in second pulse"}, vec_oe, 1);
    vec = vec_data;
    cyc(1);
    chk({tag, " R5 vector held"}, vec_data, vec);
    chk({tag, " R6 int in second pulse"}, int_req, 1);
    @(negedge clk);
    ack_n = 1'b1;
    #0.5;
    chk({tag, " R5 oe after second pulse"}, vec_oe, 0);
    chk({tag, " R5 data after second pulse"}, vec_data, 0);
    cyc(1);
  endtask

  task automatic t_reset();
    chk("R1 reset int", int_req, 0);
    chk("R1 reset oe", vec_oe, 0);
    chk("R1 reset data", vec_data, 0);
  endtask

  task automatic t_mask_retain();
    logic [7:0] v;
    raise(3);
    cyc(1);
    chk("R2 masked by default", int_req, 0);
    cfg_write(1'b1, 8'h00);
    chk("R1 R2 pending kept after unmask", int_req, 1);
    acknowledge("basic", v);
    chk("R3 default base vector", v, 8'h23);
    chk("R6 int drops after ack", int_req, 0);
    end_service();
  endtask

  task automatic t_priority();
    logic [7:0] v;
    cfg_write(1'b0, 8'h48);
    @(negedge clk);
    irq_lines = 8'b0010_0100;
    @(negedge clk);
    irq_lines = 8'h00;
    #0.5;
    chk("R3 int for two lines", int_req, 1);
    acknowledge("prio", v);
    chk("R3 lower index wins", v, 8'h4A);
    chk("R7 lower line blocked", int_req, 0);
    end_service();
    chk("R7 released after eos", int_req, 1);
    acknowledge("prio2", v);
    chk("R3 second vector", v, 8'h4D);
    end_service();
  endtask

  task automatic t_nested();
    logic [7:0] v;
    raise(6);
    acknowledge("outer", v);
    chk("R3 outer vector", v, 8'h4E);
    raise(1);
    chk("R6 higher line interrupts", int_req, 1);
    acknowledge("inner", v);
    chk("R3 inner vector", v, 8'h49);
    end_service();
    chk("R7 eos clears inner only", int_req, 0);
    raise(7);
    chk("R7 line 7 blocked by line 6", int_req, 0);
    end_service();
    chk("R7 line 7 after outer eos", int_req, 1);
    acknowledge("tail", v);
    chk("R3 tail vector", v, 8'h4F);
    end_service();
  endtask

  task automatic t_base_floor();
    logic [7:0] v;
    cfg_write(1'b0, 8'h18);
    cfg_write(1'b0, 8'h07);
    raise(0);
    acknowledge("floor", v);
    chk("R8 low base writes ignored", v, 8'h48);
    end_service();
    cfg_write(1'b0, 8'hA5);
    raise(0);
    acknowledge("newbase", v);
    chk("R8 valid base write", v, 8'hA0);
    end_service();
  endtask

  task automatic t_spurious();
    logic [7:0] v;
    chk("R9 idle before spurious", int_req, 0);
    acknowledge("spur", v);
    chk("R9 spurious vector", v, 8'hA7);
    raise(7);
    chk("R9 nothing in service", int_req, 1);
    acknowledge("spur2", v);
    end_service();
  endtask

  task automatic t_line_mask();
    logic [7:0] v;
    cfg_write(1'b1, 8'h04);
    raise(2);
    chk("R2 single masked line", int_req, 0);
    raise(4);
    chk("R2 unmasked line raises", int_req, 1);
    acknowledge("mask", v);
    chk("R2 masked higher line skipped", v, 8'hA4);
    end_service();
    chk("R2 still quiet", int_req, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_lines = '0; cfg_we = 1'b0; cfg_sel = 1'b0;
    cfg_wdata = '0; eos = 1'b0; ack_n = 1'b1;
    cyc(3);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_mask_retain();
    t_priority();
    t_nested();
    t_base_floor();
    t_spurious();
    t_line_mask();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule